// File: doc/BRIEF.md
# Decoder Host Control Register Bank

This block is the host-facing control window of a streaming audio decoder core. A host processor reaches it over a single-cycle slave bus with a 4-bit word address. Through it the host starts and resets the core, programs the byte base addresses of the input window (start and end), the output buffer and the scratch area, selects the sample byte order, and reads a small version code.

The core reports four conditions back: an idle level and three event pulses. The pulses are input exhausted, output frame written, and stream header found, which arrives with the 32-bit header word. Each event pulse sets a sticky flag that the host clears by writing 1 to it. An interrupt mask selects which status bits drive a single level interrupt line. The last header word seen is held in a read-only register.

Each access is acknowledged in the cycle after the strobe is seen. Read data is registered and presented together with that acknowledge. Unmapped addresses read as zero, and writes to them are discarded.

Top module: `dec_host_regs`

## Requirements
- R1: Word address map: 0h status/control, 1h interrupt mask, 2h input start address, 3h input end address, 4h output address, 5h scratch address, 6h header (read-only), Fh version. Any other address reads 0, and a write to it changes nothing.
- R2: An access is taken when `bus_stb` is high and `bus_ack` is low. `bus_ack` is high for exactly the next cycle. `bus_rdat` carries the read value in that cycle and is 0 in every other cycle.
- R3: A write to 0h with data bit 0 set gives a one-cycle `core_start_p` in the acknowledge cycle. Data bit 1 set gives a one-cycle `core_reset_p` in the same cycle. Status bit 0 always reads 0.
- R4: Status bit 1 reads the `core_idle` input.
- R5: Status bits 2 (input exhausted), 3 (frame written) and 4 (header found) are sticky. Each is set by its core pulse and cleared by a host write to 0h with a 1 in that bit. Writing 0 to a bit leaves it unchanged. All three reset to 0.
- R6: If a set pulse and a host clear of the same flag happen in the same cycle, the flag ends set.
- R7: A host write to 2h or 3h sets status bit 2.
- R8: The interrupt mask is 5 bits and resets to 0. `irq` is high exactly when the 5-bit status value ANDed with the mask is non-zero.
- R9: The four address registers each hold data bits 31:2 and reset to 0. They read back with bits 1:0 equal to 00 and drive their output ports.
- R10: On `core_hdr_p`, `core_hdr_word` is stored in the header register (0h after reset), and it reads back from 6h from the next cycle on. Host writes to 6h are ignored.
- R11: Fh reads 10h in bits 7:0, and bit 8 is the byte-order select (1 little-endian, 0 big-endian). The select resets to 0, is written from data bit 8, and drives `little_endian`.
- R12: Register bits above each register's defined width read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_stb | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | 4 | Word address |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Registered read data |
| bus_ack | output | 1 | Access acknowledge |
| core_idle | input | 1 | Core idle level |
| core_empty_p | input | 1 | Input exhausted pulse |
| core_frame_p | input | 1 | Frame written pulse |
| core_hdr_p | input | 1 | Header found pulse |
| core_hdr_word | input | 32 | Header word, valid with core_hdr_p |
| core_start_p | output | 1 | Start pulse to core |
| core_reset_p | output | 1 | Reset pulse to core |
| in_start_addr | output | 30 | Input start address, byte bits 31:2 |
| in_end_addr | output | 30 | Input end address, byte bits 31:2 |
| out_addr | output | 30 | Output buffer address, byte bits 31:2 |
| scratch_addr | output | 30 | Scratch area address, byte bits 31:2 |
| little_endian | output | 1 | Byte-order select |
| irq | output | 1 | Level interrupt |

## Verification
Some rules are checked by assertions on every cycle. These are the one-cycle acknowledge, start pulses that only occur with an acknowledge, a flag that is set after any set pulse even when a clear arrives in the same cycle, the flag set by writes to the input address registers, header capture, and address registers that hold when not written. Other behaviour needs the bench's reference model and its scenarios. This covers the exact read values across the map, zero for unmapped and above-width bits, ignored writes to the header, the mask-and-status interrupt, and long stretches of random bus and event traffic.

// File: rtl/dhr_pkg.sv
package dhr_pkg;
  localparam int unsigned ADR_W = 4;
  localparam logic [ADR_W-1:0] REG_CTRL    = 4'h0;
  localparam logic [ADR_W-1:0] REG_MASK    = 4'h1;
  localparam logic [ADR_W-1:0] REG_PTR0    = 4'h2;
  localparam logic [ADR_W-1:0] REG_HDR     = 4'h6;
  localparam logic [ADR_W-1:0] REG_VERSION = 4'hF;
  localparam int unsigned NUM_PTR  = 4;
  localparam int unsigned NUM_FLAG = 3;
  localparam int unsigned STAT_W   = NUM_FLAG + 2;
  localparam logic [7:0]  VERSION_CODE = 8'h10;
  localparam int unsigned LE_BIT = 8;
endpackage

// File: rtl/dhr_rst_sync.sv
module dhr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dhr_event_flags.sv
module dhr_event_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q, flag_n;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flag_n[i] = flag_q[i];
      if (clr_i[i]) flag_n[i] = 1'b0;
      if (set_i[i]) flag_n[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_n[i];
    end

    // R6: a set always lands, even against a same-cycle clear
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_q[i]);
    // R5: a clear without a set empties the flag
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_q[i]);
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/dhr_ptr_bank.sv
module dhr_ptr_bank #(
  parameter int unsigned NUM = 4,
  parameter int unsigned PW  = 30
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM-1:0]         wr_en_i,
  input  logic [PW-1:0]          wr_data_i,
  output logic [NUM-1:0][PW-1:0] ptr_o
);
  logic [NUM-1:0][PW-1:0] ptr_q, ptr_n;

  for (genvar k = 0; k < NUM; k++) begin : g_ptr
    always_comb begin
      ptr_n[k] = ptr_q[k];
      if (wr_en_i[k]) ptr_n[k] = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[k] <= '0;
      else        ptr_q[k] <= ptr_n[k];
    end

    // R9: an address register only moves on its own write
    assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i[k] |=> $stable(ptr_q[k]));
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/dec_host_regs.sv
module dec_host_regs
  import dhr_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_stb,
  input  logic             bus_we,
  input  logic [ADR_W-1:0] bus_adr,
  input  logic [DW-1:0]    bus_wdat,
  output logic [DW-1:0]    bus_rdat,
  output logic             bus_ack,
  input  logic             core_idle,
  input  logic             core_empty_p,
  input  logic             core_frame_p,
  input  logic             core_hdr_p,
  input  logic [DW-1:0]    core_hdr_word,
  output logic             core_start_p,
  output logic             core_reset_p,
  output logic [DW-3:0]    in_start_addr,
  output logic [DW-3:0]    in_end_addr,
  output logic [DW-3:0]    out_addr,
  output logic [DW-3:0]    scratch_addr,
  output logic             little_endian,
  output logic             irq
);
  localparam int unsigned PW = DW - 2;

  logic rst_n_i;
  dhr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  // access decode
  logic acc, wr, rd;
  logic sel_ctrl, sel_mask, sel_ver;
  assign acc      = bus_stb & ~bus_ack;
  assign wr       = acc & bus_we;
  assign rd       = acc & ~bus_we;
  assign sel_ctrl = (bus_adr == REG_CTRL);
  assign sel_mask = (bus_adr == REG_MASK);
  assign sel_ver  = (bus_adr == REG_VERSION);

  // address registers
  logic [NUM_PTR-1:0]         ptr_wr;
  logic [NUM_PTR-1:0][PW-1:0] ptr;
  for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr_sel
    assign ptr_wr[k] = wr & (bus_adr == ADR_W'(REG_PTR0 + k));
  end

  dhr_ptr_bank #(.NUM(NUM_PTR), .PW(PW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr_en_i   (ptr_wr),
    .wr_data_i (bus_wdat[DW-1:2]),
    .ptr_o     (ptr)
  );

  assign in_start_addr = ptr[0];
  assign in_end_addr   = ptr[1];
  assign out_addr      = ptr[2];
  assign scratch_addr  = ptr[3];

  // sticky flags: [0] input exhausted, [1] frame written, [2] header found
  logic [NUM_FLAG-1:0] flag_set, flag_clr, flags;
  assign flag_set = {core_hdr_p, core_frame_p, core_empty_p | ptr_wr[0] | ptr_wr[1]};
  assign flag_clr = (wr && sel_ctrl) ? bus_wdat[STAT_W-1:2] : '0;

  dhr_event_flags #(.N(NUM_FLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flags_o (flags)
  );

  // mask, header, byte order, pulses, read data
  logic [STAT_W-1:0] mask_q, mask_n;
  logic [DW-1:0]     hdr_q, hdr_n;
  logic              le_q, le_n;
  logic              ack_n, start_n, reset_n;
  logic [DW-1:0]     rdat_n, rd_mux;
  logic [STAT_W-1:0] status;
  logic [DW-1:0]     ver_word;

  assign status = {flags, core_idle, 1'b0};

  always_comb begin
    ver_word = '0;
    ver_word[7:0]   = VERSION_CODE;
    ver_word[LE_BIT] = le_q;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_adr)
      REG_CTRL:    rd_mux = DW'(status);
      REG_MASK:    rd_mux = DW'(mask_q);
      REG_HDR:     rd_mux = hdr_q;
      REG_VERSION: rd_mux = ver_word;
      default: begin
        for (int k = 0; k < NUM_PTR; k++)
          if (bus_adr == ADR_W'(REG_PTR0 + k)) rd_mux = {ptr[k], 2'b00};
      end
    endcase
  end

  always_comb begin
    mask_n  = mask_q;
    hdr_n   = hdr_q;
    le_n    = le_q;
    ack_n   = acc;
    start_n = wr & sel_ctrl & bus_wdat[0];
    reset_n = wr & sel_ctrl & bus_wdat[1];
    rdat_n  = rd ? rd_mux : '0;
    if (wr && sel_mask) mask_n = bus_wdat[STAT_W-1:0];
    if (wr && sel_ver)  le_n   = bus_wdat[LE_BIT];
    if (core_hdr_p)     hdr_n  = core_hdr_word;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mask_q       <= '0;
      hdr_q        <= '0;
      le_q         <= 1'b0;
      bus_ack      <= 1'b0;
      core_start_p <= 1'b0;
      core_reset_p <= 1'b0;
      bus_rdat     <= '0;
    end else begin
      mask_q       <= mask_n;
      hdr_q        <= hdr_n;
      le_q         <= le_n;
      bus_ack      <= ack_n;
      core_start_p <= start_n;
      core_reset_p <= reset_n;
      bus_rdat     <= rdat_n;
    end
  end

  assign little_endian = le_q;
  assign irq           = |(status & mask_q);

  // R2: a taken strobe is acknowledged next cycle
  assert_ack_next_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bus_stb && !bus_ack) |=> bus_ack);
  // R3: control pulses only appear with an acknowledge
  assert_start_with_ack_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (core_start_p || core_reset_p) |-> bus_ack);
  // R7: writes to the input window raise the exhausted flag
  assert_ptr_write_flag_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (ptr_wr[0] || ptr_wr[1]) |=> flags[0]);
  // R10: header word is captured on the found pulse
  assert_hdr_capture_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    core_hdr_p |=> (hdr_q == $past(core_hdr_word)));
  // R10: without a pulse the header holds, host writes included
  assert_hdr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    !core_hdr_p |=> $stable(hdr_q));
  // R8: an empty mask keeps the line low
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mask_q == '0) |-> !irq);
endmodule

// File: tb/dec_host_regs_tb_top.sv
module dec_host_regs_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_stb, bus_we;
  logic [3:0]  bus_adr;
  logic [31:0] bus_wdat, bus_rdat, core_hdr_word;
  logic        bus_ack, core_idle, core_empty_p, core_frame_p, core_hdr_p;
  logic        core_start_p, core_reset_p, little_endian, irq;
  logic [29:0] in_start_addr, in_end_addr, out_addr, scratch_addr;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_host_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_rdat(bus_rdat),
    .bus_ack(bus_ack), .core_idle(core_idle), .core_empty_p(core_empty_p),
    .core_frame_p(core_frame_p), .core_hdr_p(core_hdr_p),
    .core_hdr_word(core_hdr_word), .core_start_p(core_start_p),
    .core_reset_p(core_reset_p), .in_start_addr(in_start_addr),
    .in_end_addr(in_end_addr), .out_addr(out_addr),
    .scratch_addr(scratch_addr), .little_endian(little_endian), .irq(irq)
  );

  // reference model state
  logic        m_ack, m_start, m_reset, m_le;
  logic [31:0] m_rdat, m_hdr;
  logic [4:0]  m_mask;
  logic [2:0]  m_flags;
  logic [29:0] m_ptr [4];

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'h0: return {27'd0, m_flags, core_idle, 1'b0};
      4'h1: return {27'd0, m_mask};
      4'h2, 4'h3, 4'h4, 4'h5: return {m_ptr[a - 4'h2], 2'b00};
      4'h6: return m_hdr;
      4'hF: return {23'd0, m_le, 8'h10};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_ack = 0; m_start = 0; m_reset = 0; m_le = 0; m_rdat = 0; m_hdr = 0;
    m_mask = 0; m_flags = 0;
    for (int k = 0; k < 4; k++) m_ptr[k] = 0;
  endtask

  task automatic model_update();
    logic acc, w;
    logic [2:0] clr, set;
    acc = bus_stb && !m_ack;
    w   = acc && bus_we;
    m_rdat  = (acc && !bus_we) ? model_read(bus_adr) : 32'd0;
    m_start = w && bus_adr == 4'h0 && bus_wdat[0];
    m_reset = w && bus_adr == 4'h0 && bus_wdat[1];
    clr = (w && bus_adr == 4'h0) ? bus_wdat[4:2] : 3'd0;
    set = {core_hdr_p, core_frame_p,
           core_empty_p || (w && (bus_adr == 4'h2 || bus_adr == 4'h3))};
    m_flags = (m_flags & ~clr) | set;
    if (w && bus_adr == 4'h1) m_mask = bus_wdat[4:0];
    if (w && bus_adr >= 4'h2 && bus_adr <= 4'h5) m_ptr[bus_adr - 4'h2] = bus_wdat[31:2];
    if (w && bus_adr == 4'hF) m_le = bus_wdat[8];
    if (core_hdr_p) m_hdr = core_hdr_word;
    m_ack = acc;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 ack", {31'd0, bus_ack}, {31'd0, m_ack});
    chk("R1 R2 R12 rdat", bus_rdat, m_rdat);
    chk("R3 start", {31'd0, core_start_p}, {31'd0, m_start});
    chk("R3 reset", {31'd0, core_reset_p}, {31'd0, m_reset});
    chk("R9 in_start", {2'b0, in_start_addr}, {2'b0, m_ptr[0]});
    chk("R9 in_end", {2'b0, in_end_addr}, {2'b0, m_ptr[1]});
    chk("R9 out", {2'b0, out_addr}, {2'b0, m_ptr[2]});
    chk("R9 scratch", {2'b0, scratch_addr}, {2'b0, m_ptr[3]});
    chk("R11 little_endian", {31'd0, little_endian}, {31'd0, m_le});
    chk("R8 irq", {31'd0, irq},
        {31'd0, |({m_flags, core_idle, 1'b0} & m_mask)});
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_bus();
    bus_stb = 0; bus_we = 0; bus_adr = 0; bus_wdat = 0;
  endtask

  task automatic bw(input logic [3:0] a, input logic [31:0] d);
    bus_stb = 1; bus_we = 1; bus_adr = a; bus_wdat = d;
    step(); idle_bus(); step();
  endtask

  task automatic br(input logic [3:0] a);
    bus_stb = 1; bus_we = 0; bus_adr = a; bus_wdat = 32'hDEAD_BEEF;
    step(); idle_bus(); step();
  endtask

  logic [31:0] lfsr = 32'h1ACE_B00C;
  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 0; idle_bus();
    core_idle = 0; core_empty_p = 0; core_frame_p = 0; core_hdr_p = 0;
    core_hdr_word = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // reset state R1 R8 R9 R11
    compare_all();
    rst_n = 1;
    repeat (3) step();

    // R9: address registers, low bits dropped on read
    bw(4'h2, 32'h1234_5677); br(4'h2);
    bw(4'h3, 32'hFFFF_FFFF); br(4'h3);
    bw(4'h4, 32'h8000_0003); br(4'h4);
    bw(4'h5, 32'h0000_0004); br(4'h5);
    // R7: flag set by window writes, then cleared R5
    br(4'h0);
    bw(4'h0, 32'h0000_0004); br(4'h0);
    bw(4'h3, 32'h0000_0100); br(4'h0);
    bw(4'h0, 32'h0000_0004);
    // R4: idle level on status bit 1
    core_idle = 1; br(4'h0); core_idle = 0; br(4'h0);
    // R5: core pulses, writing 0 keeps the flag
    core_frame_p = 1; step(); core_frame_p = 0;
    bw(4'h0, 32'h0000_0000); br(4'h0);
    bw(4'h0, 32'h0000_0008); br(4'h0);
    // R10: header capture, host write to 6h ignored
    core_hdr_word = 32'hFFFB_9064; core_hdr_p = 1; step(); core_hdr_p = 0;
    core_hdr_word = 32'h0;
    br(4'h6); bw(4'h6, 32'h0BAD_0BAD); br(4'h6); br(4'h0);
    // R6: set and clear in the same cycle
    bus_stb = 1; bus_we = 1; bus_adr = 4'h0; bus_wdat = 32'h0000_001C;
    core_empty_p = 1; step(); core_empty_p = 0; idle_bus(); step();
    br(4'h0);
    // R8: mask selects interrupt sources; R12 upper mask bits dropped
    bw(4'h1, 32'hFFFF_FFE8); br(4'h1);
    bw(4'h1, 32'h0000_0004);
    bw(4'h0, 32'h0000_001C);
    bw(4'h1, 32'h0000_0002); core_idle = 1; step(); core_idle = 0; step();
    // R3: start and reset pulses, bit 0 reads 0
    bw(4'h0, 32'h0000_0001); bw(4'h0, 32'h0000_0002); bw(4'h0, 32'h0000_0003);
    br(4'h0);
    // R11: version and byte order
    br(4'hF); bw(4'hF, 32'hFFFF_FFFF); br(4'hF); bw(4'hF, 32'h0); br(4'hF);
    // R1 R12: unmapped addresses
    bw(4'h7, 32'hFFFF_FFFF); br(4'h7); br(4'hA); br(4'hE);
    // R2: strobe held high gives alternating acknowledges
    bus_stb = 1; bus_we = 0; bus_adr = 4'h4;
    repeat (5) step();
    idle_bus(); step();

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      lfsr = nxt(lfsr); lfsr = nxt(lfsr); lfsr = nxt(lfsr);
      bus_stb  = lfsr[0] | lfsr[7];
      bus_we   = lfsr[1];
      bus_adr  = lfsr[5] ? {1'b0, lfsr[4:2]} : lfsr[9:6];
      bus_wdat = nxt(lfsr) ^ {lfsr[15:0], lfsr[31:16]};
      core_idle    = lfsr[10];
      core_empty_p = lfsr[11] & lfsr[12] & lfsr[13];
      core_frame_p = lfsr[14] & lfsr[15] & lfsr[16];
      core_hdr_p   = lfsr[17] & lfsr[18];
      core_hdr_word = {lfsr[7:0], lfsr[31:8]};
      step();
    end
    idle_bus(); core_empty_p = 0; core_frame_p = 0; core_hdr_p = 0;
    step();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule